// File: doc/BRIEF.md
# Vector Register Operand Legality Checker

This decode-stage unit examines one vector instruction per cycle and decides whether its register operands are legal under the current register-group multiplier and element width. The instruction's operand-format class, its destination and two source register numbers, the mask-enable bit, the current group-multiplier code, the element-width code and a few status bits come in. One cycle later the unit reports whether the instruction must raise an illegal-instruction exception.

Legality depends on the format class. Each operand group must start on a multiple of its own size. A fractional multiplier counts as a one-register group and needs no alignment. A widening destination may share registers with a narrow source only when that source occupies exactly the upper half of the destination. A narrowing destination may land exactly on its wide source. A mask-producing destination may equal a source register outright. Register gather and compress have their own distinctness rules.

Top module: `vreg_legality_chk`

## Requirements
- R1: With `in_valid` high, the result is illegal when `vec_enable` is 0, when `cfg_illegal` is 1, or when `lmul_code` is the reserved value 3'b100. `lmul_code` is signed: 0..3 give groups of 1, 2, 4 and 8 registers, and -1..-3 are fractional.
- R2: `out_valid` equals `in_valid` delayed by one clock cycle. `out_illegal` carries the verdict for that instruction and is 0 whenever `out_valid` is 0 or reset is active.
- R3: With `unmasked` = 0, a destination of v0 is illegal for format codes 0 (same width), 2 (widen), 3 (wide-source widen), 4 (narrow) and 5 (gather). It is allowed for codes 1 (mask result) and 6 (compress).
- R4: Each operand group base must be a multiple of its group size. A fractional group needs no alignment. The first source is checked only when `src1_vec` is 1.
- R5: Formats 2, 3 and 4 are illegal when `lmul_code` is 3 or when `sew_code` >= 3. Formats 2 and 3 need the destination aligned to twice the group size.
- R6: In format 2, a source may overlap the double-size destination only if it starts above the destination base and covers exactly the destination's upper half. With a fractional multiplier, any overlap is illegal.
- R7: In format 3, the second source is aligned to twice the group size and may coincide with the destination. The first source follows the overlap rule of R6, and is checked only when `src1_vec` is 1.
- R8: In format 4, the second source is aligned to twice the group size and the destination to the group size. The destination may equal the second source; any other overlap between them is illegal.
- R9: In format 1, the destination is one register. Unless it equals a source, it must not fall inside that source's group. The first source is ignored when `src1_vec` is 0.
- R10: `fp_op` with `sew_code` 0 is illegal. `carry_op` with destination v0 is illegal.
- R11: In format 5, the destination must differ from the second source, and from the first source when `src1_vec` is 1. In format 6, the destination must differ from the second source and must not contain the one-register mask source `vs1`.
- R12: Format code 7 is reserved and always illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| fmt_code | input | 3 | Operand-format class, codes 0..6 (7 reserved) |
| vd | input | 5 | Destination register number |
| vs1 | input | 5 | First source register number (mask source for compress) |
| vs2 | input | 5 | Second source register number |
| unmasked | input | 1 | 1 = unmasked operation, 0 = masked by v0 |
| src1_vec | input | 1 | First source field names a vector register |
| lmul_code | input | 3 | Signed group-multiplier code |
| sew_code | input | 3 | Element-width code, 0 = 8 bit |
| cfg_illegal | input | 1 | Current vector configuration is illegal |
| vec_enable | input | 1 | Vector unit status is on |
| fp_op | input | 1 | Instruction is a floating-point operation |
| carry_op | input | 1 | Instruction is an add/subtract-with-carry form |
| out_valid | output | 1 | Verdict strobe, one cycle after `in_valid` |
| out_illegal | output | 1 | Instruction is illegal |

## Verification
The hardest case to reach from the ports is the widening exemption. Legality there turns on where a narrow source sits inside the double-size destination: the upper half is allowed, the lower half or a straddle is not, and the fractional multiplier removes the exemption entirely. The stimulus keeps a fixed aligned destination and steps the source between the lower half, the upper half and disjoint positions. It then repeats the same placements with a fractional multiplier and in the wide-source format, where only the first source is subject to the rule.

// File: rtl/vrl_pkg.sv
package vrl_pkg;

    localparam int REG_W  = 5;
    localparam int SZ_W   = 5;
    localparam int SP_W   = REG_W + 2;
    localparam int LMUL_W = 3;
    localparam int SEW_W  = 3;
    localparam logic [LMUL_W-1:0] LMUL_RSV    = 3'b100;
    localparam logic [LMUL_W-1:0] LMUL_MAXWID = 3'd2;
    localparam logic [SEW_W-1:0]  SEW_MAXWID  = 3'd2;

    typedef logic [REG_W-1:0] vreg_t;
    typedef logic [SZ_W-1:0]  gsize_t;
    typedef logic [SP_W-1:0]  span_t;

    typedef enum logic [2:0] {
        FMT_SAME     = 3'd0,
        FMT_MASKOUT  = 3'd1,
        FMT_WIDEN    = 3'd2,
        FMT_WIDEN_W  = 3'd3,
        FMT_NARROW   = 3'd4,
        FMT_GATHER   = 3'd5,
        FMT_COMPRESS = 3'd6
    } fmt_e;

    typedef struct packed {
        gsize_t gs;
        gsize_t dbl;
        gsize_t vd_sz;
        gsize_t vs2_sz;
        logic   lmul_rsv;
        logic   wide_ok;
    } geom_t;

    typedef struct packed {
        logic status;
        logic width;
        logic mask;
        logic align;
        logic overlap;
        logic distinct;
        logic fmt;
    } viol_t;

    function automatic span_t eff_size(gsize_t s);
        return (s == '0) ? span_t'(1) : span_t'(s);
    endfunction

    function automatic logic is_aligned(vreg_t r, gsize_t sz);
        return (sz == '0) || ((r & vreg_t'(sz - 1'b1)) == '0);
    endfunction

    function automatic logic spans_meet(span_t a, gsize_t asz, span_t b, gsize_t bsz);
        span_t ea = eff_size(asz);
        span_t eb = eff_size(bsz);
        span_t ae = a + ea;
        span_t be = b + eb;
        span_t hi = (ae > be) ? ae : be;
        span_t lo = (a < b) ? a : b;
        return (hi - lo) < (ea + eb);
    endfunction

    function automatic logic spans_meet_wide(span_t a, gsize_t asz, span_t b, gsize_t bsz);
        span_t eb = eff_size(bsz);
        if (a < b && spans_meet(a, asz, b, bsz) && !spans_meet(a, asz, b + eb, bsz))
            return 1'b0;
        return spans_meet(a, asz, b, bsz);
    endfunction

endpackage

// File: rtl/vrl_geometry.sv
module vrl_geometry
    import vrl_pkg::*;
(
    input  logic [LMUL_W-1:0] lmul_code,
    input  logic [2:0]        fmt_code,
    output geom_t             geom
);
    gsize_t gs;
    logic   frac;

    always_comb begin
        frac = lmul_code[LMUL_W-1];
        gs   = frac ? '0 : (gsize_t'(1) << lmul_code[1:0]);
    end

    always_comb begin
        geom.gs       = gs;
        geom.dbl      = gsize_t'(gs << 1);
        geom.lmul_rsv = (lmul_code == LMUL_RSV);
        geom.wide_ok  = frac || (lmul_code <= LMUL_MAXWID);
        case (fmt_code)
            FMT_WIDEN, FMT_WIDEN_W: geom.vd_sz = gsize_t'(gs << 1);
            FMT_MASKOUT:            geom.vd_sz = gsize_t'(1);
            default:                geom.vd_sz = gs;
        endcase
        case (fmt_code)
            FMT_WIDEN_W, FMT_NARROW: geom.vs2_sz = gsize_t'(gs << 1);
            default:                 geom.vs2_sz = gs;
        endcase
    end
endmodule

// File: rtl/vrl_align_unit.sv
module vrl_align_unit
    import vrl_pkg::*;
#(
    parameter int N_OPS = 3
)(
    input  vreg_t  [N_OPS-1:0] regs,
    input  gsize_t [N_OPS-1:0] sizes,
    input  logic   [N_OPS-1:0] used,
    output logic               bad
);
    logic [N_OPS-1:0] miss;

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        assign miss[i] = used[i] && !is_aligned(regs[i], sizes[i]);
    end

    assign bad = |miss;
endmodule

// File: rtl/vrl_overlap_unit.sv
module vrl_overlap_unit
    import vrl_pkg::*;
(
    input  logic [2:0] fmt_code,
    input  vreg_t      vd,
    input  vreg_t      vs1,
    input  vreg_t      vs2,
    input  logic       src1_vec,
    input  geom_t      geom,
    output logic       bad
);
    span_t d_sp, s1_sp, s2_sp;
    logic  wide_s1, wide_s2;

    function automatic logic widen_clash(span_t d, span_t s, geom_t g);
        if (g.gs == '0)
            return spans_meet(d, g.dbl, s, g.gs);
        return spans_meet_wide(d, g.dbl, s, g.gs);
    endfunction

    always_comb begin
        d_sp    = span_t'(vd);
        s1_sp   = span_t'(vs1);
        s2_sp   = span_t'(vs2);
        wide_s1 = src1_vec && widen_clash(d_sp, s1_sp, geom);
        wide_s2 = widen_clash(d_sp, s2_sp, geom);
        case (fmt_code)
            FMT_MASKOUT:
                bad = ((vd != vs2) && spans_meet(d_sp, gsize_t'(1), s2_sp, geom.gs)) ||
                      (src1_vec && (vd != vs1) && spans_meet(d_sp, gsize_t'(1), s1_sp, geom.gs));
            FMT_WIDEN:    bad = wide_s2 || wide_s1;
            FMT_WIDEN_W:  bad = wide_s1;
            FMT_NARROW:   bad = (vd != vs2) && spans_meet(d_sp, geom.gs, s2_sp, geom.dbl);
            FMT_COMPRESS: bad = spans_meet(d_sp, geom.gs, s1_sp, gsize_t'(1));
            default:      bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/vrl_policy_unit.sv
module vrl_policy_unit
    import vrl_pkg::*;
(
    input  logic [2:0]       fmt_code,
    input  vreg_t            vd,
    input  vreg_t            vs1,
    input  vreg_t            vs2,
    input  logic             unmasked,
    input  logic             src1_vec,
    input  logic [SEW_W-1:0] sew_code,
    input  logic             cfg_illegal,
    input  logic             vec_enable,
    input  logic             fp_op,
    input  logic             carry_op,
    input  geom_t            geom,
    output logic             status_bad,
    output logic             width_bad,
    output logic             mask_bad,
    output logic             distinct_bad,
    output logic             fmt_bad
);
    logic is_wide_narrow, mask_rule;

    always_comb begin
        is_wide_narrow = (fmt_code == FMT_WIDEN) || (fmt_code == FMT_WIDEN_W) ||
                         (fmt_code == FMT_NARROW);
        mask_rule      = (fmt_code == FMT_SAME) || is_wide_narrow || (fmt_code == FMT_GATHER);
        status_bad     = !vec_enable || cfg_illegal || geom.lmul_rsv;
        width_bad      = (is_wide_narrow && (!geom.wide_ok || sew_code > SEW_MAXWID)) ||
                         (fp_op && sew_code == '0);
        mask_bad       = (mask_rule && !unmasked && vd == '0) || (carry_op && vd == '0);
        case (fmt_code)
            FMT_GATHER:   distinct_bad = (vd == vs2) || (src1_vec && vd == vs1);
            FMT_COMPRESS: distinct_bad = (vd == vs2);
            default:      distinct_bad = 1'b0;
        endcase
        fmt_bad        = (fmt_code > FMT_COMPRESS);
    end
endmodule

// File: rtl/vreg_legality_chk.sv
module vreg_legality_chk
    import vrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [2:0] fmt_code,
    input  logic [4:0] vd,
    input  logic [4:0] vs1,
    input  logic [4:0] vs2,
    input  logic       unmasked,
    input  logic       src1_vec,
    input  logic [2:0] lmul_code,
    input  logic [2:0] sew_code,
    input  logic       cfg_illegal,
    input  logic       vec_enable,
    input  logic       fp_op,
    input  logic       carry_op,
    output logic       out_valid,
    output logic       out_illegal
);
    localparam int N_OPS = 3;

    geom_t  geom;
    viol_t  viol;
    vreg_t  [N_OPS-1:0] op_regs;
    gsize_t [N_OPS-1:0] op_sizes;
    logic   [N_OPS-1:0] op_used;

    vrl_geometry u_geom (
        .lmul_code (lmul_code),
        .fmt_code  (fmt_code),
        .geom      (geom)
    );

    always_comb begin
        op_regs[0]  = vd;
        op_sizes[0] = geom.vd_sz;
        op_used[0]  = 1'b1;
        op_regs[1]  = vs2;
        op_sizes[1] = geom.vs2_sz;
        op_used[1]  = 1'b1;
        op_regs[2]  = vs1;
        op_sizes[2] = geom.gs;
        op_used[2]  = src1_vec && (fmt_code != FMT_COMPRESS);
    end

    vrl_align_unit #(.N_OPS(N_OPS)) u_align (
        .regs  (op_regs),
        .sizes (op_sizes),
        .used  (op_used),
        .bad   (viol.align)
    );

    vrl_overlap_unit u_overlap (
        .fmt_code (fmt_code),
        .vd       (vd),
        .vs1      (vs1),
        .vs2      (vs2),
        .src1_vec (src1_vec),
        .geom     (geom),
        .bad      (viol.overlap)
    );

    vrl_policy_unit u_policy (
        .fmt_code     (fmt_code),
        .vd           (vd),
        .vs1          (vs1),
        .vs2          (vs2),
        .unmasked     (unmasked),
        .src1_vec     (src1_vec),
        .sew_code     (sew_code),
        .cfg_illegal  (cfg_illegal),
        .vec_enable   (vec_enable),
        .fp_op        (fp_op),
        .carry_op     (carry_op),
        .geom         (geom),
        .status_bad   (viol.status),
        .width_bad    (viol.width),
        .mask_bad     (viol.mask),
        .distinct_bad (viol.distinct),
        .fmt_bad      (viol.fmt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid && (|viol);
        end
    end
endmodule

// File: rtl/vrl_checker.sv
module vrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [2:0] fmt_code,
    input logic [4:0] vd,
    input logic [4:0] vs1,
    input logic [4:0] vs2,
    input logic       unmasked,
    input logic       src1_vec,
    input logic [2:0] lmul_code,
    input logic [2:0] sew_code,
    input logic       cfg_illegal,
    input logic       vec_enable,
    input logic       fp_op,
    input logic       carry_op,
    input logic       out_valid,
    input logic       out_illegal
);
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_FLAG_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_illegal); // R2
    AST_UNIT_GATE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (!vec_enable || cfg_illegal || lmul_code == 3'b100)) |=> out_illegal); // R1
    AST_MASKED_V0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unmasked && vd == 5'd0 && fmt_code == 3'd0) |=> out_illegal); // R3
    AST_WIDE_SEW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_code >= 3'd2 && fmt_code <= 3'd4 && sew_code >= 3'd3) |=> out_illegal); // R5
    AST_FP_BYTE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fp_op && sew_code == 3'd0) |=> out_illegal); // R10
    AST_GATHER_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_code == 3'd5 && vd == vs2) |=> out_illegal); // R11
    AST_RESERVED_FMT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_code == 3'd7) |=> out_illegal); // R12
endmodule

bind vreg_legality_chk vrl_checker u_chk (.*);

// File: tb/vreg_legality_chk_bench.sv
`timescale 1ns/1ps
module vreg_legality_chk_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [2:0] fmt_code = '0;
    logic [4:0] vd = '0, vs1 = '0, vs2 = '0;
    logic       unmasked = 1'b1, src1_vec = 1'b0;
    logic [2:0] lmul_code = '0, sew_code = '0;
    logic       cfg_illegal = 1'b0, vec_enable = 1'b1, fp_op = 1'b0, carry_op = 1'b0;
    logic       out_valid, out_illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    typedef struct {
        logic [2:0] fmt;
        logic [4:0] d, s1, s2;
        logic       um, s1v;
        logic [2:0] lm, sew;
        logic       cb, von, fp, cy;
    } stim_t;

    always #2 clk = ~clk;

    vreg_legality_chk u_vreg_legality_chk (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_code(fmt_code),
        .vd(vd), .vs1(vs1), .vs2(vs2), .unmasked(unmasked), .src1_vec(src1_vec),
        .lmul_code(lmul_code), .sew_code(sew_code), .cfg_illegal(cfg_illegal),
        .vec_enable(vec_enable), .fp_op(fp_op), .carry_op(carry_op),
        .out_valid(out_valid), .out_illegal(out_illegal)
    );

    function automatic stim_t base();
        stim_t s;
        s.fmt = 3'd0; s.d = 5'd4; s.s1 = 5'd8; s.s2 = 5'd12;
        s.um = 1'b1; s.s1v = 1'b1; s.lm = 3'd0; s.sew = 3'd2;
        s.cb = 1'b0; s.von = 1'b1; s.fp = 1'b0; s.cy = 1'b0;
        return s;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(input stim_t s, input logic exp, input string tag);
        exp_t e;
        @(negedge clk);
        fmt_code = s.fmt; vd = s.d; vs1 = s.s1; vs2 = s.s2;
        unmasked = s.um; src1_vec = s.s1v; lmul_code = s.lm; sew_code = s.sew;
        cfg_illegal = s.cb; vec_enable = s.von; fp_op = s.fp; carry_op = s.cy;
        in_valid = 1'b1;
        e.exp = exp; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops the scoreboard whenever a verdict appears
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b1, 1'b0, "R2 unexpected strobe");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_illegal, e.exp, e.tag);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid, 1'b0, "R2 reset valid");
        check(out_illegal, 1'b0, "R2 reset flag");
        @(negedge clk);
        rst = 1'b0;

        s = base(); send(s, 1'b0, "R4 same-width legal");
        s = base(); s.von = 1'b0; send(s, 1'b1, "R1 unit off");
        s = base(); s.cb = 1'b1; send(s, 1'b1, "R1 config bad");
        s = base(); s.lm = 3'b100; send(s, 1'b1, "R1 reserved lmul");

        s = base(); s.um = 1'b0; s.d = 5'd0; send(s, 1'b1, "R3 masked into v0");
        s = base(); s.um = 1'b0; send(s, 1'b0, "R3 masked into v4");
        s = base(); s.fmt = 3'd1; s.um = 1'b0; s.d = 5'd0; s.s2 = 5'd8; s.s1 = 5'd16;
        send(s, 1'b0, "R3 mask result may use v0");

        s = base(); s.lm = 3'd2; send(s, 1'b0, "R4 lmul4 aligned");
        s = base(); s.lm = 3'd2; s.d = 5'd6; send(s, 1'b1, "R4 lmul4 misaligned");
        s = base(); s.lm = 3'b111; s.d = 5'd3; s.s1 = 5'd5; s.s2 = 5'd7;
        send(s, 1'b0, "R4 fractional unaligned");
        s = base(); s.lm = 3'd2; s.s1 = 5'd9; s.s1v = 1'b0; send(s, 1'b0, "R4 scalar vs1 ignored");

        s = base(); s.fmt = 3'd2; s.lm = 3'd1; s.d = 5'd8; s.s2 = 5'd12; s.s1 = 5'd16;
        send(s, 1'b0, "R5 widen legal");
        s.d = 5'd10; send(s, 1'b1, "R5 widen dest misaligned");
        s.d = 5'd8; s.sew = 3'd3; send(s, 1'b1, "R5 widen sew64");
        s.sew = 3'd2; s.lm = 3'd3; s.d = 5'd16; s.s2 = 5'd0; s.s1 = 5'd8;
        send(s, 1'b1, "R5 widen lmul8");

        s = base(); s.fmt = 3'd2; s.lm = 3'd1; s.d = 5'd8; s.s1 = 5'd16;
        s.s2 = 5'd10; send(s, 1'b0, "R6 source in upper half");
        s.s2 = 5'd8;  send(s, 1'b1, "R6 source in lower half");
        s.s2 = 5'd16; s.s1 = 5'd10; send(s, 1'b0, "R6 vs1 upper half");
        s.s1 = 5'd6; send(s, 1'b0, "R6 vs1 disjoint below");
        s = base(); s.fmt = 3'd2; s.lm = 3'b111; s.d = 5'd4; s.s2 = 5'd4; s.s1 = 5'd9;
        send(s, 1'b1, "R6 fractional overlap");
        s.s2 = 5'd5; send(s, 1'b0, "R6 fractional adjacent");

        s = base(); s.fmt = 3'd3; s.lm = 3'd1; s.d = 5'd8; s.s2 = 5'd12; s.s1 = 5'd16;
        send(s, 1'b0, "R7 wide-source legal");
        s.s2 = 5'd14; send(s, 1'b1, "R7 vs2 misaligned");
        s.s2 = 5'd8;  send(s, 1'b0, "R7 vs2 equals dest");
        s.s1 = 5'd8;  send(s, 1'b1, "R7 vs1 lower half");
        s.s1v = 1'b0; send(s, 1'b0, "R7 scalar vs1 ignored");

        s = base(); s.fmt = 3'd4; s.lm = 3'd1; s.d = 5'd8; s.s2 = 5'd8; s.s1 = 5'd16;
        send(s, 1'b0, "R8 narrow onto source");
        s.d = 5'd10; send(s, 1'b1, "R8 narrow partial overlap");
        s.d = 5'd12; send(s, 1'b0, "R8 narrow disjoint");
        s.d = 5'd9;  send(s, 1'b1, "R8 narrow misaligned");

        s = base(); s.fmt = 3'd1; s.lm = 3'd2; s.d = 5'd9; s.s2 = 5'd8; s.s1 = 5'd16;
        send(s, 1'b1, "R9 dest inside vs2 group");
        s.d = 5'd8;  send(s, 1'b0, "R9 dest equals vs2");
        s.d = 5'd17; s.s1v = 1'b0; send(s, 1'b0, "R9 scalar vs1 ignored");
        s.s1v = 1'b1; send(s, 1'b1, "R9 dest inside vs1 group");

        s = base(); s.fp = 1'b1; s.sew = 3'd0; send(s, 1'b1, "R10 fp byte");
        s.sew = 3'd1; send(s, 1'b0, "R10 fp half");
        s = base(); s.cy = 1'b1; s.d = 5'd0; send(s, 1'b1, "R10 carry into v0");

        s = base(); s.fmt = 3'd5; send(s, 1'b0, "R11 gather legal");
        s.d = 5'd12; send(s, 1'b1, "R11 gather vd=vs2");
        s.d = 5'd8;  send(s, 1'b1, "R11 gather vd=vs1");
        s.s1v = 1'b0; send(s, 1'b0, "R11 gather scalar index");
        s = base(); s.fmt = 3'd6; s.lm = 3'd1; s.s1 = 5'd5; s.s1v = 1'b0;
        send(s, 1'b1, "R11 compress covers mask");
        s.s1 = 5'd0; send(s, 1'b0, "R11 compress legal");
        s.d = 5'd12; send(s, 1'b1, "R11 compress vd=vs2");

        s = base(); s.fmt = 3'd7; send(s, 1'b1, "R12 reserved format");

        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(out_valid, 1'b0, "R2 idle valid");
        check(out_illegal, 1'b0, "R2 idle flag");
        check(exp_q.size() == 0, 1'b1, "R2 all verdicts seen");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule